// File: doc/BRIEF.md
# Presettable Binary Up-Counter with Trickle Enable

This block is a small synchronous up-counter with a parallel preset. It counts modulo 2^WIDTH, which is modulo 16 at the default width of four bits. It serves as a programmable divider, or as one stage of a wider synchronous counter. An active-low load strobe copies a preset word into the count on a clock edge. Two enables must both be high for the count to advance. The first enable (`en_par`) is shared by every stage of a chain. The second (`en_trk`) also gates the terminal-count flag, so stages can be cascaded: each stage's flag feeds the next stage's second enable.

An active-low clear has the highest priority. The parameter `CLEAR_ASYNC` chooses how it acts. With `CLEAR_ASYNC` = 1 the clear zeroes the count at once, without waiting for a clock edge. With `CLEAR_ASYNC` = 0 it zeroes the count on the next rising edge. Below the clear, the priority order is load, then count, then hold. The terminal-count flag is combinational and has no register stage.

Top module: `preset_counter`

## Requirements
- R1: With `CLEAR_ASYNC` = 0, `clr_n` low at a rising edge makes `count` zero after that edge; before that edge `count` keeps its value.
- R2: With `CLEAR_ASYNC` = 1, `clr_n` going low forces `count` to zero at once, with no clock edge, and it stays zero while `clr_n` is low.
- R3: The clear wins over load and over count in both variants.
- R4: With `clr_n` high and `load_n` low, the next rising edge copies `preset` into `count`, whatever the enables are.
- R5: With `clr_n` and `load_n` high and both `en_par` and `en_trk` high, each rising edge adds one to `count`.
- R6: A count of all ones (15 at width 4) becomes 0 on a counting edge.
- R7: With `clr_n` and `load_n` high, `count` holds when either enable is low.
- R8: `tc` is 1 exactly when `count` is all ones and `en_trk` is 1, in the same cycle. It does not depend on `en_par` or `load_n`.
- R9: Two stages form a correct 8-bit synchronous counter, including across 255 to 0, when they share `en_par`, `load_n` and `clr_n`, and the lower stage's `tc` drives the upper stage's `en_trk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rising edge is active |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per `CLEAR_ASYNC` |
| load_n | input | 1 | Active-low parallel-load strobe |
| preset | input | WIDTH | Value that is loaded |
| en_par | input | 1 | Count enable shared across a chain |
| en_trk | input | 1 | Count enable that also gates `tc` |
| count | output | WIDTH | Current count |
| tc | output | 1 | Terminal-count flag |

## Verification
The directed runs try each mode on its own:
- A clear held over several edges.
- Free counting past the wrap.
- Holds with each enable low in turn.
- Loads with the enables both high and both low.
- A load issued together with a clear.

Each of these separates one level of the priority order from the level below it. A clear is also dropped midway between edges: the asynchronous instance must read zero before the next edge, while the synchronous instance still shows its old value. With the count parked at all ones, `en_trk` and `en_par` are toggled separately, which shows that only the trickle enable moves the flag. A long random mix then drives both variants and a two-stage chain. The chain is preloaded just below 255 so that it crosses 255 to 0, and it is compared against an 8-bit counter model.

// File: rtl/preset_counter.sv
module preset_counter #(
  parameter int WIDTH       = 4,
  parameter bit CLEAR_ASYNC = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             en_par,
  input  logic             en_trk,
  output logic [WIDTH-1:0] count,
  output logic             tc
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic             run;
  logic [WIDTH-1:0] nxt;

  assign run = load_n & en_par & en_trk;
  assign nxt = !load_n ? preset : (run ? count + 1'b1 : count);
  assign tc  = en_trk & (count == ALL_ONES);

  generate
    if (CLEAR_ASYNC) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n)
        if (!clr_n) count <= '0;
        else        count <= nxt;

      // R2, R3: while clear is low the count reads zero at every edge
      a_r2_async_zero: assert property (@(posedge clk) !clr_n |-> count == '0);
    end else begin : g_sync_clr
      always_ff @(posedge clk)
        if (!clr_n) count <= '0;
        else        count <= nxt;

      // R1, R3: a clear seen at an edge leaves zero after it
      a_r1_sync_zero: assert property (@(posedge clk) !clr_n |=> count == '0);
    end
  endgenerate

  a_r4_load: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(preset));

  a_r5_increment: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk) |=> count == WIDTH'($past(count) + 1'b1));

  a_r6_wrap_after_tc: assert property (@(posedge clk) disable iff (!clr_n)
    (tc && en_par && load_n) |=> count == '0);

  a_r7_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_trk)) |=> $stable(count));

  a_r8_tc_gated: assert property (@(posedge clk) disable iff (!clr_n)
    !en_trk |-> !tc);

endmodule

// File: tb/preset_counter_bench.sv
`timescale 1ns/1ps
module preset_counter_bench;

  logic       clk = 1'b0;
  logic       clr_n = 1'b0, load_n = 1'b1, par = 1'b0, trk = 1'b0;
  logic [3:0] pv = '0;
  logic [7:0] pv8 = '0;

  logic [3:0] cnt_a, cnt_s, cnt_lo, cnt_hi;
  logic       tc_a, tc_s, tc_lo, tc_hi;

  int checks = 0, errors = 0;
  int m_a = 0, m_s = 0, m_8 = 0;
  string tag_a = "R2", tag_s = "R1";

  always #2 clk = ~clk;

  preset_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b1)) u_preset_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(pv),
    .en_par(par), .en_trk(trk), .count(cnt_a), .tc(tc_a));

  preset_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b0)) u_preset_counter_sync (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(pv),
    .en_par(par), .en_trk(trk), .count(cnt_s), .tc(tc_s));

  preset_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b0)) u_chain_lo (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(pv8[3:0]),
    .en_par(par), .en_trk(trk), .count(cnt_lo), .tc(tc_lo));

  preset_counter #(.WIDTH(4), .CLEAR_ASYNC(1'b0)) u_chain_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(pv8[7:4]),
    .en_par(par), .en_trk(tc_lo), .count(cnt_hi), .tc(tc_hi));

  // Reference models: precedence clear > load > count > hold
  always @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin m_a = 0; tag_a = "R2"; end
    else if (!load_n) begin m_a = pv; tag_a = "R4"; end
    else if (par && trk) begin tag_a = (m_a == 15) ? "R6" : "R5"; m_a = (m_a + 1) % 16; end
    else tag_a = "R7";
  end

  always @(posedge clk) begin
    if (!clr_n) begin
      tag_s = (!load_n || (par && trk)) ? "R3" : "R1";
      m_s = 0; m_8 = 0;
    end else if (!load_n) begin
      m_s = pv; m_8 = pv8; tag_s = "R4";
    end else if (par && trk) begin
      tag_s = (m_s == 15) ? "R6" : "R5";
      m_s = (m_s + 1) % 16; m_8 = (m_8 + 1) % 256;
    end else tag_s = "R7";
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(tag_a, int'(cnt_a), m_a);
    chk(tag_s, int'(cnt_s), m_s);
    chk("R8 tc async inst", int'(tc_a), int'(m_a == 15 && trk));
    chk("R8 tc sync inst", int'(tc_s), int'(m_s == 15 && trk));
    chk("R9 chain count", int'({cnt_hi, cnt_lo}), m_8);
    chk("R9 chain tc", int'(tc_hi), int'(m_8 == 255 && trk));
  endtask

  task automatic cyc(input logic c, input logic l, input logic p, input logic t,
                     input logic [3:0] v, input logic [7:0] v8);
    logic was_clr;
    @(negedge clk);
    compare_all();
    was_clr = clr_n;
    clr_n = c; load_n = l; par = p; trk = t; pv = v; pv8 = v8;
    #0.5;
    // R8: flag follows en_trk within the same cycle
    chk("R8 same cycle", int'(tc_s), int'(m_s == 15 && t));
    if (was_clr && !c) begin
      chk("R2 immediate clear", int'(cnt_a), 0);
      chk("R1 no clear before edge", int'(cnt_s), m_s);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state (R1, R2)
    repeat (3) cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 8'h00);
    // free counting across the wrap (R5, R6)
    repeat (20) cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 8'h00);
    // holds (R7)
    repeat (3) cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 8'h00);
    repeat (3) cyc(1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 8'h00);
    // loads with enables high and low (R4)
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'hA, 8'h5A);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'h3, 8'h33);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00);
    // clear beats load (R3)
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 4'h9, 8'h99);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00);
    // park at 15, toggle enables (R8)
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 8'hFF);
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 8'h00);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 8'h00);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 8'h00);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 4'h2, 8'h02);
    // mid-count clear dropped between edges (R2 vs R1)
    repeat (4) cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 4'h0, 8'h00);
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 8'h00);
    // chain across 255 -> 0 (R9)
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 4'h0, 8'hF6);
    repeat (24) cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 8'h00);
    repeat (300) cyc(1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 8'h00);
    // random mix
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 40) != 0, ($urandom % 12) != 0, ($urandom % 10) < 8,
          ($urandom % 10) < 8, 4'($urandom), 8'($urandom));
    @(negedge clk);
    compare_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule